// File: doc/BRIEF.md
# Bus Cycle Termination Monitor

This block sits beside the master of a 16-bit external bus and decides, one clock edge at a time, how each bus cycle ends. A cycle opens when the address strobe is seen high while the monitor is idle. From the next edge on, the monitor samples the slave-side acknowledges and the error inputs on every rising clock edge. A cycle ends normally when either data-size acknowledge bit or the autovector acknowledge is seen. It ends in a bus error when no acknowledge arrives before a selectable timeout, when an interrupt-acknowledge cycle finds no contender on the arbitration inputs, or when an external device reports a bus error.

The result is a single-clock done pulse, a two-bit code that says which cause closed the cycle, and an exception request that accompanies every error ending. A halt input turns the bus into single-step operation: a cycle that ends while halt is high blocks the next cycle until halt is seen low. Exception handling and the bus master itself lie outside this block.

Top module: `bus_term_mon`

## Requirements
- R1: In an open cycle with the strobe high, an edge that samples size_ack bit 0, size_ack bit 1 or avec_ack (and no error cause) closes the cycle; one clock later cyc_done is high for one clock with term_code 2'b00 and exc_req low.
- R2: The timeout length is 8 << tmo_sel clocks (8, 16, 32, 64). If no termination occurs on the first limit-1 evaluation edges of a cycle, the limit-th evaluation edge closes it with term_code 2'b01; the count restarts at every new cycle.
- R3: An evaluation edge that samples iack_cycle high and arb_contend low closes the cycle with term_code 2'b10 (spurious interrupt); with arb_contend high the cycle waits for an acknowledge as usual.
- R4: An evaluation edge that samples ext_berr high closes the cycle with term_code 2'b11.
- R5: When several causes are sampled on one edge, the code follows the priority external error (11) over spurious (10) over timeout (01) over acknowledge (00).
- R6: exc_req is high exactly when cyc_done is high with a nonzero term_code.
- R7: If halt_req is sampled high on the edge that closes a cycle, cyc_hold rises and no new cycle opens until halt_req has been sampled low; the first cycle can open on the edge after that.
- R8: Dropping the strobe during an open cycle abandons it with no cyc_done; after a cycle closes, a new one opens only after the strobe has been seen low.
- R9: Acknowledge and error inputs have no effect while no cycle is open, including on the edge that opens a cycle; the first evaluation edge is the one after it.
- R10: While reset is low, and after it is released, cyc_done, term_code, exc_req and cyc_hold read zero until a cycle closes.
- R11: cyc_done is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| addr_strobe | input | 1 | Address strobe, high while the master runs a cycle |
| size_ack | input | ACK_W | Data-size acknowledge lines, any bit ends the cycle |
| avec_ack | input | 1 | Autovector acknowledge |
| iack_cycle | input | 1 | High when the current cycle is an interrupt acknowledge |
| arb_contend | input | 1 | High when an interrupt source takes part in arbitration |
| ext_berr | input | 1 | Bus error driven from outside |
| halt_req | input | 1 | Single-step request |
| tmo_sel | input | SEL_W | Timeout select, limit = 8 << tmo_sel clocks |
| cyc_done | output | 1 | One-clock pulse when a cycle closes |
| term_code | output | 2 | Cause of the ending, valid with cyc_done |
| exc_req | output | 1 | Bus-error exception request, with cyc_done |
| cyc_hold | output | 1 | High while the next cycle is held off by halt |

## Verification
The causes that can coincide on one evaluation edge are an acknowledge and a bus error, in particular the timeout expiring on the very edge an acknowledge arrives, and an external error landing together with a spurious interrupt and an acknowledge. The bench provokes the first by holding the acknowledge back until the last counted edge of an eight-clock timeout, and the second by raising all three causes with the strobe. Each is judged by the code and the exact clock of the done pulse against the priority order, with the exception request checked on the same pulse.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

  typedef enum logic [1:0] {
    TC_NORMAL  = 2'b00,
    TC_TIMEOUT = 2'b01,
    TC_SPUR    = 2'b10,
    TC_EXTERR  = 2'b11
  } term_code_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BUSY  = 2'b01,
    ST_DRAIN = 2'b10
  } cyc_state_t;

endpackage

// File: rtl/btm_rst_sync.sv
module btm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/btm_wdog.sv
module btm_wdog #(
  parameter int TMO_BASE = 8,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);

  localparam int MAX_LIM = TMO_BASE << ((1 << SEL_W) - 1);
  localparam int CW      = (MAX_LIM > 2) ? $clog2(MAX_LIM) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last_val;

  always_comb begin
    last_val = CW'((TMO_BASE << sel) - 1);
    expire   = (cnt_q == last_val);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        cnt_q <= '0;
    else if (clr || en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/btm_resolve.sv
module btm_resolve
  import bus_term_pkg::*;
(
  input  logic       live,
  input  logic       ack_any,
  input  logic       iack_cycle,
  input  logic       arb_contend,
  input  logic       ext_berr,
  input  logic       tmo_hit,
  output logic       term,
  output term_code_t code
);

  logic spur;

  always_comb begin
    spur = iack_cycle && !arb_contend;
    term = 1'b0;
    code = TC_NORMAL;
    if (live) begin
      if (ext_berr) begin
        term = 1'b1;
        code = TC_EXTERR;
      end else if (spur) begin
        term = 1'b1;
        code = TC_SPUR;
      end else if (tmo_hit) begin
        term = 1'b1;
        code = TC_TIMEOUT;
      end else if (ack_any) begin
        term = 1'b1;
        code = TC_NORMAL;
      end
    end
  end

endmodule

// File: rtl/bus_term_mon.sv
module bus_term_mon
  import bus_term_pkg::*;
#(
  parameter int ACK_W      = 2,
  parameter int TMO_BASE   = 8,
  parameter int SEL_W      = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_strobe,
  input  logic [ACK_W-1:0] size_ack,
  input  logic             avec_ack,
  input  logic             iack_cycle,
  input  logic             arb_contend,
  input  logic             ext_berr,
  input  logic             halt_req,
  input  logic [SEL_W-1:0] tmo_sel,
  output logic             cyc_done,
  output logic [1:0]       term_code,
  output logic             exc_req,
  output logic             cyc_hold
);

  logic       srst_n;
  cyc_state_t state_q, state_d;
  logic       hold_q, hold_d;
  logic       done_q, done_d;
  term_code_t code_q, code_d;
  logic       exc_q, exc_d;

  logic       busy, live, start, ack_any, tmo_hit, term;
  term_code_t term_kind;

  btm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    busy    = (state_q == ST_BUSY);
    live    = busy && addr_strobe;
    start   = (state_q == ST_IDLE) && addr_strobe && !hold_q;
    ack_any = (|size_ack) || avec_ack;
  end

  btm_wdog #(.TMO_BASE(TMO_BASE), .SEL_W(SEL_W)) u_wdog (
    .clk    (clk),
    .srst_n (srst_n),
    .clr    (start),
    .en     (live && !term),
    .sel    (tmo_sel),
    .expire (tmo_hit)
  );

  btm_resolve u_res (
    .live        (live),
    .ack_any     (ack_any),
    .iack_cycle  (iack_cycle),
    .arb_contend (arb_contend),
    .ext_berr    (ext_berr),
    .tmo_hit     (tmo_hit),
    .term        (term),
    .code        (term_kind)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_BUSY;
      ST_BUSY: begin
        if (!addr_strobe) state_d = ST_IDLE;
        else if (term)    state_d = ST_DRAIN;
      end
      ST_DRAIN: if (!addr_strobe) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    hold_d = halt_req && (hold_q || term);
    done_d = term;
    code_d = term ? term_kind : TC_NORMAL;
    exc_d  = term && (term_kind != TC_NORMAL);
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
      done_q  <= 1'b0;
      code_q  <= TC_NORMAL;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      done_q  <= done_d;
      code_q  <= code_d;
      exc_q   <= exc_d;
    end
  end

  assign cyc_done  = done_q;
  assign term_code = code_q;
  assign exc_req   = exc_q;
  assign cyc_hold  = hold_q;

endmodule

// File: rtl/bus_term_mon_chk.sv
module bus_term_mon_chk #(
  parameter int ACK_W = 2
) (
  input logic             clk,
  input logic             srst_n,
  input logic             addr_strobe,
  input logic [ACK_W-1:0] size_ack,
  input logic             avec_ack,
  input logic             iack_cycle,
  input logic             arb_contend,
  input logic             ext_berr,
  input logic             busy,
  input logic             tmo_hit,
  input logic             cyc_done,
  input logic [1:0]       term_code,
  input logic             exc_req,
  input logic             cyc_hold
);

  logic spur_seen;
  assign spur_seen = iack_cycle && !arb_contend;

  a_r1_ack_normal: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && addr_strobe && ((|size_ack) || avec_ack) && !ext_berr && !spur_seen && !tmo_hit)
      |=> (cyc_done && term_code == 2'b00 && !exc_req));

  a_r2_timeout: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && addr_strobe && tmo_hit && !ext_berr && !spur_seen)
      |=> (cyc_done && term_code == 2'b01));

  a_r3_spurious: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && addr_strobe && !ext_berr && spur_seen)
      |=> (cyc_done && term_code == 2'b10));

  a_r4_ext_err: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && addr_strobe && ext_berr)
      |=> (cyc_done && term_code == 2'b11 && exc_req));

  a_r6_exc_with_done: assert property (@(posedge clk) disable iff (!srst_n)
    exc_req |-> (cyc_done && term_code != 2'b00));

  a_r7_hold_blocks: assert property (@(posedge clk) disable iff (!srst_n)
    (cyc_hold && !busy) |=> !busy);

  a_r8_abort: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !addr_strobe) |=> (!cyc_done && !busy));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    !busy |=> !cyc_done);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    cyc_done |=> !cyc_done);

endmodule

bind bus_term_mon bus_term_mon_chk #(.ACK_W(ACK_W)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .addr_strobe (addr_strobe),
  .size_ack    (size_ack),
  .avec_ack    (avec_ack),
  .iack_cycle  (iack_cycle),
  .arb_contend (arb_contend),
  .ext_berr    (ext_berr),
  .busy        (busy),
  .tmo_hit     (tmo_hit),
  .cyc_done    (cyc_done),
  .term_code   (term_code),
  .exc_req     (exc_req),
  .cyc_hold    (cyc_hold)
);

// File: tb/sim_bus_term_mon.sv
module sim_bus_term_mon;

  logic       clk;
  logic       rst_n;
  logic       strobe;
  logic [1:0] size;
  logic       avec, iack, contend, berr, halt;
  logic [1:0] sel;
  logic       done;
  logic [1:0] code;
  logic       exc, hold;

  typedef struct {
    logic [1:0] code;
    int         stamp;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0;
  int   bad    = 0;
  int   cnt    = 0;
  int   done_count = 0;
  logic mon_on = 1'b0;
  logic prev_done = 1'b0;

  bus_term_mon u0 (
    .clk(clk), .rst_n(rst_n), .addr_strobe(strobe), .size_ack(size),
    .avec_ack(avec), .iack_cycle(iack), .arb_contend(contend),
    .ext_berr(berr), .halt_req(halt), .tmo_sel(sel),
    .cyc_done(done), .term_code(code), .exc_req(exc), .cyc_hold(hold)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expectations as done pulses appear
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        done_count++;
        if (prev_done) chk(1'b0, "R11 done on consecutive clocks", 1, 0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R9 unexpected done", int'(code), -1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(code === e.code, {e.tag, " code"}, int'(code), int'(e.code));
          chk(cnt == e.stamp, {e.tag, " timing"}, cnt, e.stamp);
          chk(exc === (e.code != 2'b00), {e.tag, " R6 exc_req"}, int'(exc), int'(e.code != 2'b00));
        end
      end else if (exc) begin
        chk(1'b0, "R6 exc_req without done", 1, 0);
      end
      prev_done = done;
    end
  end

  task automatic idle_inputs();
    strobe = 1'b0; size = 2'b00; avec = 1'b0;
    iack = 1'b0; contend = 1'b0; berr = 1'b0;
  endtask

  // driver: opens a cycle, schedules the acknowledge, pushes the expectation
  task automatic do_cycle(input logic [1:0] sz, input logic av, input logic iq,
                          input logic ct, input logic eb, input int ack_dly,
                          input int lat, input logic [1:0] c, input string tag);
    exp_t e;
    @(negedge clk);
    strobe = 1'b1; iack = iq; contend = ct; berr = eb;
    e.code = c; e.stamp = cnt + 1 + lat; e.tag = tag;
    sbq.push_back(e);
    for (int i = 0; i <= lat; i++) begin
      if (i == ack_dly) begin size = sz; avec = av; end
      @(negedge clk);
    end
    idle_inputs();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", cnt, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int snap;
    rst_n = 1'b0; halt = 1'b0; sel = 2'b00;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R10 done in reset", int'(done), 0);
    chk(exc === 1'b0, "R10 exc in reset", int'(exc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    chk(code === 2'b00, "R10 code after reset", int'(code), 0);
    chk(hold === 1'b0, "R10 hold after reset", int'(hold), 0);

    // R1 normal endings on each acknowledge line
    do_cycle(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 2'b00, "R1 size bit0");
    do_cycle(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2, 2, 2'b00, "R1 size bit1 late");
    do_cycle(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1, 1, 2'b00, "R1 autovector");

    // R2 timeouts for several selects
    sel = 2'b00;
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 8, 2'b01, "R2 timeout 8");
    sel = 2'b01;
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 16, 2'b01, "R2 timeout 16");
    sel = 2'b11;
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 64, 2'b01, "R2 timeout 64");
    sel = 2'b00;
    do_cycle(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 7, 7, 2'b00, "R2 ack one edge before limit");

    // R5 timeout and acknowledge on the same edge
    do_cycle(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8, 8, 2'b01, "R5 timeout beats ack");

    // R3 spurious interrupt, and contention cancels it
    do_cycle(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, -1, 1, 2'b10, "R3 spurious");
    do_cycle(2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 3, 3, 2'b00, "R3 contender present");
    do_cycle(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1, 2'b10, "R5 spurious beats ack");

    // R4 external error, R5 against everything else
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, -1, 1, 2'b11, "R4 external error");
    do_cycle(2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 0, 1, 2'b11, "R5 external beats all");

    // R9 inputs ignored while idle
    snap = done_count;
    @(negedge clk);
    berr = 1'b1; size = 2'b11; avec = 1'b1; iack = 1'b1;
    repeat (6) @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    chk(done_count == snap, "R9 idle inputs ignored", done_count - snap, 0);

    // R8 abort with strobe drop, then a fresh full timeout
    snap = done_count;
    @(negedge clk);
    strobe = 1'b1;
    repeat (5) @(negedge clk);
    strobe = 1'b0;
    repeat (12) @(negedge clk);
    chk(done_count == snap, "R8 abort gives no done", done_count - snap, 0);
    do_cycle(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1, 8, 2'b01, "R8 R2 count restarts");

    // R8 strobe held high after the end: only one done
    snap = done_count;
    begin
      exp_t e;
      @(negedge clk);
      strobe = 1'b1; size = 2'b01;
      e.code = 2'b00; e.stamp = cnt + 2; e.tag = "R8 held strobe";
      sbq.push_back(e);
      repeat (8) @(negedge clk);
      idle_inputs();
      repeat (2) @(negedge clk);
    end
    chk(done_count == snap + 1, "R8 one done per strobe", done_count - snap, 1);

    // R7 halt single stepping
    halt = 1'b1;
    do_cycle(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 2'b00, "R7 halted cycle");
    chk(hold === 1'b1, "R7 hold raised", int'(hold), 1);
    snap = done_count;
    @(negedge clk);
    strobe = 1'b1; size = 2'b10;
    repeat (6) @(negedge clk);
    chk(done_count == snap, "R7 next cycle held", done_count - snap, 0);
    chk(hold === 1'b1, "R7 hold kept", int'(hold), 1);
    begin
      exp_t e;
      halt = 1'b0;
      e.code = 2'b00; e.stamp = cnt + 3; e.tag = "R7 release";
      sbq.push_back(e);
      repeat (3) @(negedge clk);
      idle_inputs();
      repeat (2) @(negedge clk);
    end
    chk(hold === 1'b0, "R7 hold cleared", int'(hold), 0);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R1 all expected endings seen", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule